// File: doc/BRIEF.md
# Single-Error Hamming Word Corrector

This block takes a W-bit word laid out as an even-parity Hamming codeword and decides whether it is, or can be made, a valid codeword by inverting no more than one bit. Bit `word_i[p-1]` holds codeword position `p`, with positions counted from 1. The check bits sit at the power-of-two positions. The check group owned by position 2^k is every position whose index has bit k set. For example, the check bit at position 4 covers positions 4, 5, 6, 7, 12 and so on, as far as the word reaches.

The result is W+1 bits wide. The top bit is a repairability flag. Below it is either the repaired word or, when no single inversion can produce a valid codeword, the input unchanged. The width parameter covers 3 to 30 bits. A parameter selects a purely combinational path or one output register for timing closure.

Top module: `hfix_corrector`

## Requirements
- R1: `result_o[W]` is 1 exactly when the input is a valid codeword or lies one bit inversion away from one. Otherwise it is 0.
- R2: A valid codeword (every check group holds an even count of ones) is returned unchanged in `result_o[W-1:0]`, with the flag set.
- R3: When the XOR of the 1-based indices of all set bits equals a position p in 1..W, bit `p-1` is inverted in the output and the flag is set.
- R4: When that XOR names a position above W, the flag is 0 and `result_o[W-1:0]` equals the input.
- R5: The check group for position 2^k holds exactly the positions whose index has bit k set. For example, a word with only positions 1, 4 and 5 set is valid.
- R6: With `REG_OUT`=1, the result appears on the first rising edge after the input is applied, and the register reads all zeros while `rst_ni` is low.
- R7: With `REG_OUT`=0, the result follows `word_i` in the same cycle, with no clock edge between them.
- R8: `result_o[W-1:0]` never differs from the input in more than one bit position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| word_i | input | W | Received word; bit p-1 is position p |
| result_o | output | W+1 | Flag in bit W, repaired or unchanged word below |

## Verification
On every cycle, the assertions check four things: a zero syndrome leaves the word untouched with the flag set, an in-range syndrome inverts exactly the named bit, an unrepairable word passes through intact, and the output never strays more than one bit from the input. Only the bench's exhaustive sweeps can show two further properties. The first is that the flag agrees with a distance search over all valid codewords. The second is that the check groups match their definition, for a width that yields unrepairable syndromes and for one registered configuration. The bench also confirms register latency and the cleared state during reset.

// File: rtl/hfix_pkg.sv
package hfix_pkg;
  localparam int unsigned MIN_W = 3;
  localparam int unsigned MAX_W = 30;

  // bits needed to name any 1-based position of a w-bit word
  function automatic int unsigned syn_bits(input int unsigned w);
    return $clog2(w + 1);
  endfunction

  function automatic bit in_group(input int unsigned pos, input int unsigned k);
    return ((pos >> k) & 1) != 0;
  endfunction
endpackage

// File: rtl/hfix_syndrome.sv
module hfix_syndrome
  import hfix_pkg::*;
#(
  parameter int unsigned W  = 12,
  parameter int unsigned SB = syn_bits(W)
) (
  input  logic [W-1:0]  word_i,
  output logic [SB-1:0] syn_o
);
  for (genvar k = 0; k < SB; k++) begin : g_chk
    logic [W-1:0] sel;
    for (genvar p = 0; p < W; p++) begin : g_pos
      if (in_group(p + 1, k)) begin : g_in
        assign sel[p] = word_i[p];
      end else begin : g_out
        assign sel[p] = 1'b0;
      end
    end
    assign syn_o[k] = ^sel;
  end
endmodule

// File: rtl/hfix_flip.sv
module hfix_flip
  import hfix_pkg::*;
#(
  parameter int unsigned W  = 12,
  parameter int unsigned SB = syn_bits(W)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [W-1:0]  word_i,
  input  logic [SB-1:0] syn_i,
  output logic [W-1:0]  fixed_o,
  output logic          fix_o
);
  logic [W-1:0] hit;

  for (genvar p = 0; p < W; p++) begin : g_dec
    assign hit[p] = (syn_i == SB'(p + 1));
  end

  assign fix_o   = (32'(syn_i) <= 32'(W));
  assign fixed_o = word_i ^ hit;

  p_one_flip_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(word_i ^ fixed_o) <= 1);

  p_unfix_passthru_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fix_o |-> (fixed_o == word_i));
endmodule

// File: rtl/hfix_out_stage.sv
module hfix_out_stage #(
  parameter int unsigned W       = 12,
  parameter bit          REG_OUT = 1'b0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [W:0] d_i,
  output logic [W:0] q_o
);
  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_o <= '0;
      else         q_o <= d_i;
    end
  end else begin : g_comb
    logic unused_clk;
    assign unused_clk = clk_i ^ rst_ni;
    assign q_o = d_i;
  end
endmodule

// File: rtl/hfix_corrector.sv
module hfix_corrector
  import hfix_pkg::*;
#(
  parameter int unsigned W       = 12,
  parameter bit          REG_OUT = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] word_i,
  output logic [W:0]   result_o
);
  localparam int unsigned SB = syn_bits(W);

  initial assert (W >= MIN_W && W <= MAX_W);

  logic [SB-1:0] syn;
  logic [W-1:0]  fixed;
  logic          fix;

  hfix_syndrome #(.W(W), .SB(SB)) u_syn (
    .word_i (word_i),
    .syn_o  (syn)
  );

  hfix_flip #(.W(W), .SB(SB)) u_flip (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .word_i  (word_i),
    .syn_i   (syn),
    .fixed_o (fixed),
    .fix_o   (fix)
  );

  hfix_out_stage #(.W(W), .REG_OUT(REG_OUT)) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({fix, fixed}),
    .q_o    (result_o)
  );

  p_clean_word_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (syn == '0) |-> (fix && fixed == word_i));

  p_named_bit_flipped_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (syn != '0 && 32'(syn) <= 32'(W)) |-> (fixed[syn - 1'b1] != word_i[syn - 1'b1]));
endmodule

// File: tb/hfix_corrector_test.sv
`timescale 1ns/1ps
module hfix_corrector_test;
  localparam int unsigned WR = 10;
  localparam int unsigned WC = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [WR-1:0] word_r = '0;
  logic [WC-1:0] word_c = '0;
  logic [WR:0]   res_r;
  logic [WC:0]   res_c;
  int            n_run = 0;
  int            n_fail = 0;
  bit            done = 1'b0;

  always #2 clk = ~clk;

  hfix_corrector #(.W(WR), .REG_OUT(1'b1)) uut (
    .clk_i (clk), .rst_ni (rst_n), .word_i (word_r), .result_o (res_r));

  hfix_corrector #(.W(WC), .REG_OUT(1'b0)) uut_comb (
    .clk_i (clk), .rst_ni (rst_n), .word_i (word_c), .result_o (res_c));

  // per-group even parity, group 2^k = positions with bit k set (R5)
  function automatic bit valid_cw(input logic [31:0] x, input int w);
    for (int k = 0; k < 5; k++) begin
      bit par = 1'b0;
      for (int p = 1; p <= w; p++)
        if (((p >> k) & 1) != 0) par ^= x[p-1];
      if (par) return 1'b0;
    end
    return 1'b1;
  endfunction

  // distance search; returns flag in bit w
  function automatic logic [31:0] expect_of(input logic [31:0] x, input int w,
                                            output int kind);
    logic [31:0] f = 32'd1 << w;
    if (valid_cw(x, w)) begin kind = 2; return x | f; end
    for (int j = 0; j < w; j++)
      if (valid_cw(x ^ (32'd1 << j), w)) begin
        kind = 3; return (x ^ (32'd1 << j)) | f;
      end
    kind = 4;
    return x;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic string tag(input int kind);
    case (kind)
      2: return "R2";
      3: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [31:0] e;
    int kind;
    int n_unfix = 0;
    #5;
    check("R6 reset clear", 32'(res_r), 32'd0);
    @(negedge clk); rst_n = 1'b1;

    // R5: positions 1,4,5 form a valid word
    @(negedge clk); word_c = 5'b11001; #1;
    check("R5 group4", 32'(res_c), 32'h39);

    // registered, exhaustive: R1..R4, R6, R8
    for (int v = 0; v < (1 << WR); v++) begin
      @(negedge clk); word_r = WR'(v);
      e = expect_of(32'(v), WR, kind);
      if (kind == 4) n_unfix++;
      @(posedge clk); #1;
      check({tag(kind), " R1 R6 reg"}, 32'(res_r), e);
      check("R8 one flip", 32'($countones(res_r[WR-1:0] ^ WR'(v)) <= 1), 32'd1);
    end
    check("R4 unfixable seen", 32'(n_unfix > 0), 32'd1);

    // combinational, exhaustive: R1..R4, R7
    for (int v = 0; v < (1 << WC); v++) begin
      @(negedge clk); word_c = WC'(v); #1;
      e = expect_of(32'(v), WC, kind);
      check({tag(kind), " R1 R7 comb"}, 32'(res_c), e);
    end

    // R6: reset asserted again clears the register
    @(negedge clk); word_r = '1; @(posedge clk); #1;
    rst_n = 1'b0; #1;
    check("R6 async clear", 32'(res_r), 32'd0);
    done = 1'b1;
    finish_run();
  end
endmodule